// File: doc/BRIEF.md
# Transmit Echo Error Checker

This block checks an outgoing serial stream while it is being sent. A remote station sends each received bit back, and the block compares that echo with a delayed copy of the local transmit line. The delay allows for the round trip. It is set to one or two bit times. A bit strobe from the transmitter's baud logic marks each bit. On that strobe the local bit and its position within the character go into a short delay line. On the same strobe the entry at the selected tap is compared with the echo bit.

When the two differ, the block raises a sticky error flag and pulses an interrupt request. It also records the position of the bit that failed. A further mismatch before software clears the flag sets an overrun flag, and the first recorded position is kept. No processor work is needed per byte.

The checker does nothing while it is disabled. After it is enabled, comparison waits until enough bits have passed through the delay line to fill the selected tap.

Top module: `echoVerifier`

## Requirements
- R1: After reset, errFlag, overrunFlag and errIrq are 0 and errPos is 0.
- R2: With delaySel = 0 (one bit time), the echo bit sampled on a bitStrobe is compared with the txBit given on the previous bitStrobe while enabled.
- R3: With delaySel = 1 (two bit times), the echo bit sampled on a bitStrobe is compared with the txBit given two bitStrobes earlier while enabled.
- R4: A mismatch sets errFlag one clock after the strobe, and errFlag stays set until clearErr. When errFlag was clear, errPos takes the bitIdx that went in with the failing transmit bit.
- R5: errIrq is high for exactly the one clock after each strobe on which a mismatch is found, and for no other clock.
- R6: A mismatch while errFlag is already set, with no clearErr in that cycle, sets overrunFlag and leaves errPos unchanged.
- R7: clearErr clears errFlag and overrunFlag on the next clock. If a mismatch is found in the same cycle, errFlag is set again, errPos takes the new position and overrunFlag stays clear.
- R8: While enable is low, nothing is compared and nothing is shifted, and the delay line is emptied.
- R9: After enable rises, no comparison takes place until as many enabled strobes as the selected delay have been taken in.
- R10: On a clock with bitStrobe low, no comparison is made. Without clearErr, the flags and errPos keep their values on such a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Checker enable; low empties the delay line |
| delaySel | input | 1 | Compare delay minus one, in bit times (0: one, 1: two) |
| clearErr | input | 1 | One-cycle pulse that clears the error and overrun flags |
| bitStrobe | input | 1 | One-cycle marker for each transmitted and echoed bit |
| txBit | input | 1 | Local transmit line value for this bit |
| bitIdx | input | 4 | Position of this bit within the character frame |
| echoBit | input | 1 | Echo bit returned by the remote receiver |
| errFlag | output | 1 | Sticky mismatch flag |
| overrunFlag | output | 1 | Sticky flag for a mismatch while errFlag was set |
| errIrq | output | 1 | One-cycle interrupt pulse per detected mismatch |
| errPos | output | 4 | Frame position of the first recorded failing bit |

## Verification
The bench sends clean echoes at both delay settings, so that no error may appear. It also sends an echo taken at the wrong delay, which gives mismatches only when the tap is selected correctly and tells the two settings apart.

Single and double bit flips at known frame positions test the recorded position, the overrun flag and the rule that the first position is kept. One clear is given alone and one in the same cycle as a mismatch. Strobes sent while disabled, strobes right after enable with garbage echoes, and idle clocks with wrong echo values show that comparison is suppressed in each of those cases.

// File: rtl/echoChkPkg.sv
package echoChkPkg;
  typedef struct packed {
    logic shiftEn;
    logic flush;
    logic cmpEn;
    logic capturePos;
  } chkStrobe_t;
endpackage

// File: rtl/echoChkPath.sv
module echoChkPath
  import echoChkPkg::*;
#(
  parameter int MAX_DELAY = 2,
  parameter int IDX_W = 4,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  chkStrobe_t       strobes,
  input  logic [SEL_W-1:0] delaySel,
  input  logic             txBit,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             echoBit,
  output logic             mismatch,
  output logic [IDX_W-1:0] errPos
);
  localparam int ENT_W = IDX_W + 1;

  logic [ENT_W-1:0] stage [MAX_DELAY];
  logic [ENT_W-1:0] tap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < MAX_DELAY; k++) stage[k] <= '0;
    end else if (strobes.flush) begin
      for (int k = 0; k < MAX_DELAY; k++) stage[k] <= '0;
    end else if (strobes.shiftEn) begin
      stage[0] <= {txBit, bitIdx};
      for (int k = 1; k < MAX_DELAY; k++) stage[k] <= stage[k-1];
    end
  end

  always_comb begin
    tap = stage[MAX_DELAY-1];
    for (int k = 0; k < MAX_DELAY; k++)
      if (delaySel == SEL_W'(k)) tap = stage[k];
  end

  assign mismatch = strobes.cmpEn & (tap[ENT_W-1] ^ echoBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errPos <= '0;
    else if (strobes.capturePos) errPos <= tap[IDX_W-1:0];
  end
endmodule

// File: rtl/echoChkCtrl.sv
module echoChkCtrl
  import echoChkPkg::*;
#(
  parameter int MAX_DELAY = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bitStrobe,
  input  logic             clearErr,
  input  logic [SEL_W-1:0] delaySel,
  input  logic             mismatch,
  output chkStrobe_t       strobes,
  output logic             errFlag,
  output logic             overrunFlag,
  output logic             errIrq
);
  localparam int CNT_W = $clog2(MAX_DELAY + 1);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] needFill;
  logic             newErr;

  assign needFill = CNT_W'(delaySel) + CNT_W'(1);
  assign newErr   = mismatch;

  always_comb begin
    strobes.shiftEn    = enable & bitStrobe;
    strobes.flush      = ~enable;
    strobes.cmpEn      = enable & bitStrobe & (fillCnt >= needFill);
    strobes.capturePos = mismatch & (~errFlag | clearErr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillCnt <= '0;
    else if (!enable) fillCnt <= '0;
    else if (bitStrobe && fillCnt != CNT_W'(MAX_DELAY)) fillCnt <= fillCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag     <= 1'b0;
      overrunFlag <= 1'b0;
      errIrq      <= 1'b0;
    end else begin
      errIrq      <= newErr;
      errFlag     <= newErr | (errFlag & ~clearErr);
      overrunFlag <= ~clearErr & (overrunFlag | (newErr & errFlag));
    end
  end
endmodule

// File: rtl/echoVerifier.sv
module echoVerifier
  import echoChkPkg::*;
#(
  parameter int MAX_DELAY = 2,
  parameter int IDX_W = 4,
  localparam int SEL_W = (MAX_DELAY > 1) ? $clog2(MAX_DELAY) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] delaySel,
  input  logic             clearErr,
  input  logic             bitStrobe,
  input  logic             txBit,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             echoBit,
  output logic             errFlag,
  output logic             overrunFlag,
  output logic             errIrq,
  output logic [IDX_W-1:0] errPos
);
  chkStrobe_t strobes;
  logic       mismatch;

  echoChkCtrl #(.MAX_DELAY(MAX_DELAY), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitStrobe(bitStrobe),
    .clearErr(clearErr), .delaySel(delaySel), .mismatch(mismatch),
    .strobes(strobes), .errFlag(errFlag), .overrunFlag(overrunFlag),
    .errIrq(errIrq)
  );

  echoChkPath #(.MAX_DELAY(MAX_DELAY), .IDX_W(IDX_W), .SEL_W(SEL_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .delaySel(delaySel),
    .txBit(txBit), .bitIdx(bitIdx), .echoBit(echoBit),
    .mismatch(mismatch), .errPos(errPos)
  );
endmodule

// File: rtl/echoVerifierChecker.sv
module echoVerifierChecker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             clearErr,
  input logic             bitStrobe,
  input logic             errFlag,
  input logic             overrunFlag,
  input logic             errIrq,
  input logic [IDX_W-1:0] errPos
);
  assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> errFlag);

  assert_overrun_has_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |-> errFlag);

  assert_pos_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearErr) |=> $stable(errPos));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearErr) |=> errFlag);

  assert_clear_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearErr |=> !overrunFlag);

  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !errIrq);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!bitStrobe && !clearErr) |=> (!errIrq && $stable(errFlag) && $stable(errPos)
                                   && $stable(overrunFlag)));
endmodule

bind echoVerifier echoVerifierChecker #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .clearErr(clearErr),
  .bitStrobe(bitStrobe), .errFlag(errFlag), .overrunFlag(overrunFlag),
  .errIrq(errIrq), .errPos(errPos)
);

// File: tb/tb_echoVerifier.sv
`timescale 1ns/1ps
module tb_echoVerifier;
  logic       clk = 1'b0;
  logic       rstN;
  logic       enable, delaySel, clearErr, bitStrobe, txBit, echoBit;
  logic [3:0] bitIdx;
  logic       errFlag, overrunFlag, errIrq;
  logic [3:0] errPos;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [4:0] mq[$];
  logic [0:0] eh[$];
  logic       mErr = 0, mOvr = 0, mIrq = 0;
  logic [3:0] mPos = 0;

  always #2 clk = ~clk;

  echoVerifier dut (
    .clk(clk), .rstN(rstN), .enable(enable), .delaySel(delaySel),
    .clearErr(clearErr), .bitStrobe(bitStrobe), .txBit(txBit),
    .bitIdx(bitIdx), .echoBit(echoBit), .errFlag(errFlag),
    .overrunFlag(overrunFlag), .errIrq(errIrq), .errPos(errPos)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "errFlag", errFlag, mErr);
    chk(tag, "overrunFlag", overrunFlag, mOvr);
    chk(tag, "errIrq", errIrq, mIrq);
    chk(tag, "errPos", errPos, mPos);
  endtask

  task automatic step(input string tag, input logic en, input logic sel, input logic strb,
                      input logic tb, input logic [3:0] idx, input logic eb, input logic clr);
    logic newErr;
    logic [3:0] tapPos;
    int d;
    @(negedge clk);
    enable = en; delaySel = sel; bitStrobe = strb; txBit = tb; bitIdx = idx;
    echoBit = eb; clearErr = clr;
    @(posedge clk);
    d = int'(sel) + 1;
    newErr = 1'b0;
    tapPos = 4'd0;
    if (en && strb && mq.size() >= d) begin
      newErr = (mq[d-1][4] != eb);
      tapPos = mq[d-1][3:0];
    end
    mOvr = (newErr && mErr && !clr) || (mOvr && !clr);
    if (newErr && (!mErr || clr)) mPos = tapPos;
    mErr = newErr || (mErr && !clr);
    mIrq = newErr;
    if (!en) mq.delete();
    else if (strb) begin
      mq.push_front({tb, idx});
      if (mq.size() > 2) void'(mq.pop_back());
    end
    #1;
    compareAll(tag);
  endtask

  // send one bit; echo is the line value echoDly strobes earlier, optionally flipped
  task automatic sendBit(input string tag, input logic sel, input int echoDly,
                         input logic tb, input logic [3:0] idx, input logic flip,
                         input logic clr);
    logic eb;
    eb = (eh.size() >= echoDly) ? eh[echoDly-1][0] : ~tb;
    step(tag, 1'b1, sel, 1'b1, tb, idx, eb ^ flip, clr);
    eh.push_front(tb);
    if (eh.size() > 2) void'(eh.pop_back());
  endtask

  task automatic sendByte(input string tag, input logic sel, input int echoDly,
                          input logic [7:0] data, input int flipAt);
    for (int i = 0; i < 8; i++) begin
      sendBit(tag, sel, echoDly, data[i], 4'(i), (i == flipAt), 1'b0);
      step("R10", 1'b1, sel, 1'b0, 1'b0, 4'd0, ~data[i], 1'b0);
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired before completion (R1..R10 run incomplete)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 0; delaySel = 0; clearErr = 0; bitStrobe = 0;
    txBit = 0; bitIdx = 0; echoBit = 0;
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;

    // R8: strobes while disabled with bad echoes
    for (int i = 0; i < 4; i++) step("R8", 1'b0, 1'b0, 1'b1, 1'b1, 4'(i), 1'b0, 1'b0);

    // R9 + R2: one-bit delay, first echo garbage, then clean
    eh.delete();
    sendByte("R2", 1'b0, 1, 8'hA5, -1);
    sendByte("R2", 1'b0, 1, 8'h3C, -1);

    // R8: disable empties pipeline
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0);
    eh.delete();

    // R9 + R3: two-bit delay, clean
    sendByte("R3", 1'b1, 2, 8'h96, -1);
    sendByte("R3", 1'b1, 2, 8'h0F, -1);

    // R3: echo taken at one-bit delay while two selected gives mismatches
    sendByte("R3", 1'b1, 1, 8'h55, -1);
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1);

    // realign the echo history, then clear
    sendByte("R3", 1'b1, 2, 8'hFF, -1);
    sendByte("R3", 1'b1, 2, 8'h00, -1);
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1);

    // R4: single flip at position 5
    sendByte("R4", 1'b1, 2, 8'hC3, 5);
    // R6: second flip at position 2 -> overrun, position kept
    sendByte("R6", 1'b1, 2, 8'h5A, 2);

    // R7: clear alone
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
    sendBit("R4", 1'b1, 2, 1'b1, 4'd6, 1'b1, 1'b0);
    sendBit("R6", 1'b1, 2, 1'b0, 4'd7, 1'b1, 1'b0);
    // R7: clear in same cycle as new mismatch
    sendBit("R7", 1'b1, 2, 1'b1, 4'd3, 1'b1, 1'b1);
    sendBit("R5", 1'b1, 2, 1'b0, 4'd4, 1'b0, 1'b0);

    // R2 with flip under one-bit delay
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
    sendByte("R2", 1'b0, 1, 8'h81, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule